// File: doc/BRIEF.md
# Nine-Bit Serial Display Link Transmitter

This block sends commands and parameters to a small LCD controller over a transmit-only serial link. The host offers items on a valid/ready interface. Each item is a command/data flag and a payload byte. The block turns each item into a 9-bit serial word: the flag goes out first, then the byte. It drives an active-low chip select, a serial clock that idles low, and a data line. The clock runs at the system clock divided by `DIV`.

The `emul_mode` input selects the framing. In native framing the link ends a burst as soon as a word finishes and no item is waiting. In emulation framing the same 9-bit words form one continuous bit stream, but the stream is always released in whole bytes. Eight words (72 bits, exactly nine bytes) make a group, and a burst only ends on a group boundary. If the host stops in the middle of a group, the link holds chip select low with the clock stopped and waits. The `flush` input closes a partial group: zero bits are added up to the next byte boundary, then chip select is released.

The controller states are as follows:
- `ST_IDLE`: chip select high, ready for a new item.
- `ST_SHIFT`: a word is shifting out.
- `ST_HOLD`: emulation framing only; the link waits inside a partial group with the clock stopped.
- `ST_PAD`: zero pad bits are shifting out.
- `ST_GAP`: chip select is high for one full serial clock period.

The transitions are as follows:
- IDLE→SHIFT: an item is accepted.
- SHIFT→SHIFT: the next item is accepted at a word end.
- SHIFT→HOLD: a word ends in emulation framing, no item is waiting and the group is partial.
- SHIFT→PAD: a word ends with a flush pending in emulation framing and the group is partial.
- SHIFT→GAP: a word ends and the burst is over.
- HOLD→SHIFT: a new item arrives.
- HOLD→PAD: a flush arrives.
- PAD→GAP: the last pad bit ends.
- GAP→IDLE: the gap period ends.

Top module: `sl9_link`

## Requirements
- R1: After reset, `cs_n` is 1, `sclk` is 0, `sdo` is 0 and `in_ready` is 1.
- R2: Each accepted item is sent as 9 bits, each sampled on a rising `sclk` edge. The flag comes first (0 = command, 1 = parameter or pixel data), followed by the payload byte, most significant bit first.
- R3: `sclk` is 0 whenever `cs_n` is 1. `sdo` does not change while `sclk` stays high. Each `sclk` high phase lasts `DIV - DIV/2` system cycles. Successive rising edges are at least `DIV` cycles apart.
- R4: In native framing (`emul_mode` = 0), items presented back to back share one chip-select burst. The burst ends after a word when no item is waiting.
- R5: In emulation framing (`emul_mode` = 1), when the host pauses inside a partial group, `cs_n` stays 0 and `sclk` stays 0 until the next item or a flush. A completed group of 8 words (72 bits) ends the burst if no item is waiting.
- R6: A flush in emulation framing with k words (1 to 7) in the current group adds 8 − k zero bits after the last word, then ends the burst. A flush in native framing ends the burst after the current word with no padding.
- R7: A flush while the link is idle has no effect: `cs_n` stays 1 and no bits are sent.
- R8: Between two bursts, `cs_n` stays 1 for at least `DIV` system cycles.
- R9: While a flush is pending, no new item is accepted. An item offered at that time is sent in the next burst.
- R10: In emulation framing, the word after a completed group starts a new group within the same burst when it is already waiting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | An item is offered |
| in_dc | input | 1 | Item flag: 0 command, 1 data |
| in_byte | input | 8 | Item payload byte |
| in_ready | output | 1 | Item accepted on this cycle when `in_valid` is also high |
| emul_mode | input | 1 | 1 selects byte-packed emulation framing |
| flush | input | 1 | Closes the current burst (pads a partial group in emulation framing) |
| cs_n | output | 1 | Active-low chip select |
| sclk | output | 1 | Serial clock, idle low |
| sdo | output | 1 | Serial data, changed while `sclk` is low |

## Verification
The assertions assume that `emul_mode` is constant for the duration of a burst. They also assume that `in_dc` and `in_byte` are stable while `in_valid` waits for `in_ready`. The bench changes the framing only after the link has been idle for several serial periods. It presents items at falling system-clock edges and holds them until a rising edge accepts them. Flush pulses last one cycle and are issued during a burst, or deliberately while idle, to check that an idle flush is ignored.

// File: rtl/sl9_pkg.sv
package sl9_pkg;

    localparam int PAYLOAD_BITS = 8;
    localparam int WORD_BITS    = PAYLOAD_BITS + 1;
    localparam int GROUP_WORDS  = 8;
    localparam int GRP_W        = $clog2(GROUP_WORDS);
    localparam int PAD_W        = $clog2(GROUP_WORDS + 1);
    localparam int BL_W         = $clog2(WORD_BITS + 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SHIFT,
        ST_HOLD,
        ST_PAD,
        ST_GAP
    } link_state_t;

endpackage

// File: rtl/sl9_bit_timer.sv
module sl9_bit_timer #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic ph_end,
    output logic hi_half
);
    localparam int PH_W    = (DIV > 2) ? $clog2(DIV) : 1;
    localparam int LOW_CYC = DIV / 2;

    logic [PH_W-1:0] ph;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph <= '0;
        end else if (!run) begin
            ph <= '0;
        end else if (ph == PH_W'(DIV - 1)) begin
            ph <= '0;
        end else begin
            ph <= ph + 1'b1;
        end
    end

    assign ph_end  = run && (ph == PH_W'(DIV - 1));
    assign hi_half = run && (ph >= PH_W'(LOW_CYC));

    // R3: the phase counter never leaves its period
    a_r3_phase_bound: assert property (@(posedge clk) disable iff (!rst_n)
        ph <= PH_W'(DIV - 1));

endmodule

// File: rtl/sl9_word_shifter.sv
module sl9_word_shifter
    import sl9_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load,
    input  logic                    advance,
    input  logic                    dc,
    input  logic [PAYLOAD_BITS-1:0] data,
    output logic                    bit_out,
    output logic                    last_bit
);
    logic [WORD_BITS-1:0] sh;
    logic [BL_W-1:0]      bits_left;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh        <= '0;
            bits_left <= '0;
        end else if (load) begin
            sh        <= {dc, data};
            bits_left <= BL_W'(WORD_BITS);
        end else if (advance) begin
            sh        <= {sh[WORD_BITS-2:0], 1'b0};
            bits_left <= bits_left - 1'b1;
        end
    end

    assign bit_out  = sh[WORD_BITS-1];
    assign last_bit = (bits_left == BL_W'(1));

    // R2: a shift is only requested while bits of the word remain
    a_r2_shift_in_word: assert property (@(posedge clk) disable iff (!rst_n)
        advance |-> (bits_left > BL_W'(1)));

endmodule

// File: rtl/sl9_fsm.sv
module sl9_fsm
    import sl9_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic emul_mode,
    input  logic flush,
    input  logic ph_end,
    input  logic hi_half,
    input  logic last_bit,
    input  logic bit_out,
    output logic in_ready,
    output logic load,
    output logic advance,
    output logic run,
    output logic cs_n,
    output logic sclk,
    output logic sdo
);
    link_state_t      state, nxt;
    logic [GRP_W-1:0] grp;
    logic [PAD_W-1:0] pad_left;
    logic             flush_pend;
    logic             fl;
    logic             to_pad;

    assign fl = flush | flush_pend;

    always_comb begin
        in_ready = 1'b0;
        unique case (state)
            ST_IDLE:  in_ready = 1'b1;
            ST_SHIFT: in_ready = ph_end && last_bit && !fl;
            ST_HOLD:  in_ready = !fl;
            default:  in_ready = 1'b0;
        endcase
    end

    assign load = in_valid && in_ready;

    always_comb begin
        nxt     = state;
        advance = 1'b0;
        to_pad  = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (in_valid) nxt = ST_SHIFT;
            end
            ST_SHIFT: begin
                if (ph_end) begin
                    if (!last_bit) begin
                        advance = 1'b1;
                    end else if (fl) begin
                        if (emul_mode && grp != '0) begin
                            nxt    = ST_PAD;
                            to_pad = 1'b1;
                        end else begin
                            nxt = ST_GAP;
                        end
                    end else if (in_valid) begin
                        nxt = ST_SHIFT;
                    end else if (emul_mode && grp != '0) begin
                        nxt = ST_HOLD;
                    end else begin
                        nxt = ST_GAP;
                    end
                end
            end
            ST_HOLD: begin
                if (fl) begin
                    nxt    = ST_PAD;
                    to_pad = 1'b1;
                end else if (in_valid) begin
                    nxt = ST_SHIFT;
                end
            end
            ST_PAD: begin
                if (ph_end && pad_left == PAD_W'(1)) nxt = ST_GAP;
            end
            ST_GAP: begin
                if (ph_end) nxt = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            grp        <= '0;
            pad_left   <= '0;
            flush_pend <= 1'b0;
        end else begin
            state <= nxt;
            if (load) begin
                grp <= (state == ST_IDLE) ? GRP_W'(1) : grp + 1'b1;
            end
            if (to_pad) begin
                pad_left <= PAD_W'(GROUP_WORDS) - {1'b0, grp};
            end else if (state == ST_PAD && ph_end) begin
                pad_left <= pad_left - 1'b1;
            end
            if (nxt == ST_GAP || nxt == ST_IDLE) begin
                flush_pend <= 1'b0;
            end else if (flush && state != ST_IDLE) begin
                flush_pend <= 1'b1;
            end
        end
    end

    always_comb begin
        run  = (state == ST_SHIFT) || (state == ST_PAD) || (state == ST_GAP);
        cs_n = !((state == ST_SHIFT) || (state == ST_HOLD) || (state == ST_PAD));
        sclk = ((state == ST_SHIFT) || (state == ST_PAD)) && hi_half;
        sdo  = (state == ST_SHIFT) && bit_out;
    end

    // R3: clock stays low outside a burst
    a_r3_sclk_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk);

    // R3: data held while the clock is high
    a_r3_sdo_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(sdo));

    // R8: chip select high for more than one cycle after a burst
    a_r8_gap_min: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |=> cs_n);

    // R4: no item taken in the middle of a word
    a_r4_no_midword_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SHIFT && !last_bit) |-> !in_ready);

    // R5: a held group only resumes, pads or stays held
    a_r5_hold_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD) |=> (state == ST_HOLD || state == ST_SHIFT || state == ST_PAD));

    // R6: pad length lies between 1 and 7 bits
    a_r6_pad_range: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PAD) |-> (pad_left >= PAD_W'(1) && pad_left < PAD_W'(GROUP_WORDS)));

endmodule

// File: rtl/sl9_link.sv
module sl9_link
    import sl9_pkg::*;
#(
    parameter int DIV = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic                    in_dc,
    input  logic [PAYLOAD_BITS-1:0] in_byte,
    output logic                    in_ready,
    input  logic                    emul_mode,
    input  logic                    flush,
    output logic                    cs_n,
    output logic                    sclk,
    output logic                    sdo
);
    logic ph_end, hi_half, run;
    logic load, advance, bit_out, last_bit;

    sl9_bit_timer #(.DIV(DIV)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .ph_end  (ph_end),
        .hi_half (hi_half)
    );

    sl9_word_shifter u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .advance  (advance),
        .dc       (in_dc),
        .data     (in_byte),
        .bit_out  (bit_out),
        .last_bit (last_bit)
    );

    sl9_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .emul_mode (emul_mode),
        .flush     (flush),
        .ph_end    (ph_end),
        .hi_half   (hi_half),
        .last_bit  (last_bit),
        .bit_out   (bit_out),
        .in_ready  (in_ready),
        .load      (load),
        .advance   (advance),
        .run       (run),
        .cs_n      (cs_n),
        .sclk      (sclk),
        .sdo       (sdo)
    );

endmodule

// File: tb/sl9_link_tb.sv
module sl9_link_tb;
    localparam int DIV = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_dc = 1'b0;
    logic [7:0] in_byte = 8'h00;
    logic       emul_mode = 1'b0;
    logic       flush = 1'b0;
    logic       in_ready, cs_n, sclk, sdo;

    always #5 clk = ~clk;

    sl9_link #(.DIV(DIV)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_dc(in_dc),
        .in_byte(in_byte), .in_ready(in_ready), .emul_mode(emul_mode),
        .flush(flush), .cs_n(cs_n), .sclk(sclk), .sdo(sdo)
    );

    int checks = 0;
    int errors = 0;
    bit got[$];
    bit exp_q[$];
    int bursts = 0;
    int cyc = 0;
    int last_rise = -1;
    int cs_rise_cyc = -1;
    int hi_run = 0;
    logic prev_sclk = 1'b0;
    logic prev_sdo = 1'b0;
    logic prev_cs = 1'b1;

    task automatic chk(input bit ok, input string req, input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, expv, $time);
        end
    endtask

    // Reference model of the wire: every clock, compare the line behaviour
    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            if (cs_n) chk(!sclk, "R3 clock idle low", sclk, 0);
            if (prev_sclk && sclk) chk(sdo == prev_sdo, "R3 data stable while high", sdo, prev_sdo);
            if (sclk && !prev_sclk && !cs_n) begin
                got.push_back(sdo);
                if (last_rise >= 0) chk(cyc - last_rise >= DIV, "R3 clock period", cyc - last_rise, DIV);
                last_rise = cyc;
            end
            if (!sclk && prev_sclk) chk(hi_run == DIV - DIV / 2, "R3 high phase", hi_run, DIV - DIV / 2);
            hi_run = sclk ? hi_run + 1 : 0;
            if (cs_n && !prev_cs) begin
                bursts++;
                cs_rise_cyc = cyc;
                last_rise = -1;
            end
            if (!cs_n && prev_cs && cs_rise_cyc >= 0)
                chk(cyc - cs_rise_cyc >= DIV, "R8 gap between bursts", cyc - cs_rise_cyc, DIV);
            prev_sclk = sclk;
            prev_sdo  = sdo;
            prev_cs   = cs_n;
        end
    end

    task automatic exp_word(input bit dc, input logic [7:0] b);
        exp_q.push_back(dc);
        for (int i = 7; i >= 0; i--) exp_q.push_back(b[i]);
    endtask

    task automatic exp_pad(input int n);
        for (int i = 0; i < n; i++) exp_q.push_back(1'b0);
    endtask

    task automatic push(input bit dc, input logic [7:0] b);
        @(negedge clk);
        in_valid = 1'b1; in_dc = dc; in_byte = b;
        #1;
        while (!in_ready) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        #1;
        in_valid = 1'b0;
    endtask

    task automatic pulse_flush();
        @(negedge clk);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
    endtask

    task automatic wait_idle();
        int q = 0;
        while (q < 3 * DIV) begin
            @(negedge clk);
            q = cs_n ? q + 1 : 0;
        end
    endtask

    task automatic start_test(input bit emul);
        @(negedge clk);
        emul_mode = emul;
        got.delete();
        exp_q.delete();
        bursts = 0;
    endtask

    task automatic compare(input string req, input int exp_bursts);
        int bad = -1;
        chk(got.size() == exp_q.size(), req, got.size(), exp_q.size());
        for (int i = 0; i < got.size() && i < exp_q.size(); i++)
            if (bad < 0 && got[i] != exp_q[i]) bad = i;
        if (bad >= 0) chk(1'b0, req, got[bad], exp_q[bad]);
        else chk(1'b1, req, 0, 0);
        chk(bursts == exp_bursts, {req, " burst count"}, bursts, exp_bursts);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk(cs_n == 1'b1, "R1 cs_n", cs_n, 1);
        chk(sclk == 1'b0, "R1 sclk", sclk, 0);
        chk(sdo == 1'b0, "R1 sdo", sdo, 0);
        chk(in_ready == 1'b1, "R1 in_ready", in_ready, 1);

        // R2 single command word, native
        start_test(1'b0);
        push(1'b0, 8'h2C); exp_word(1'b0, 8'h2C);
        wait_idle();
        compare("R2 single command", 1);

        // R4 command plus parameters back to back, one burst
        start_test(1'b0);
        push(1'b0, 8'hB5); exp_word(1'b0, 8'hB5);
        push(1'b1, 8'h35); exp_word(1'b1, 8'h35);
        push(1'b1, 8'h20); exp_word(1'b1, 8'h20);
        push(1'b1, 8'h45); exp_word(1'b1, 8'h45);
        wait_idle();
        compare("R4 native burst", 1);

        // R4 / R8 pause between items in native framing gives two bursts
        start_test(1'b0);
        push(1'b0, 8'h11); exp_word(1'b0, 8'h11);
        wait_idle();
        push(1'b1, 8'hA5); exp_word(1'b1, 8'hA5);
        wait_idle();
        compare("R4 native pause", 2);

        // R5 full group of eight words in emulation, no flush
        start_test(1'b1);
        for (int i = 0; i < 8; i++) begin
            push(i != 0, 8'(i * 37 + 5)); exp_word(i != 0, 8'(i * 37 + 5));
        end
        wait_idle();
        compare("R5 full group", 1);

        // R6 three words plus flush: 5 pad bits
        start_test(1'b1);
        push(1'b0, 8'h3A); exp_word(1'b0, 8'h3A);
        push(1'b1, 8'h05); exp_word(1'b1, 8'h05);
        push(1'b1, 8'hFF); exp_word(1'b1, 8'hFF);
        pulse_flush(); exp_pad(5);
        wait_idle();
        compare("R6 flush three words", 1);

        // R5 pause inside a group holds chip select
        start_test(1'b1);
        push(1'b0, 8'hC1); exp_word(1'b0, 8'hC1);
        push(1'b1, 8'hFF); exp_word(1'b1, 8'hFF);
        repeat (30 * DIV) @(negedge clk);
        chk(cs_n == 1'b0, "R5 hold keeps cs low", cs_n, 0);
        chk(sclk == 1'b0, "R5 hold stops clock", sclk, 0);
        push(1'b1, 8'h83); exp_word(1'b1, 8'h83);
        pulse_flush(); exp_pad(5);
        wait_idle();
        compare("R5 hold then resume", 1);

        // R10 nine words then flush: new group within same burst, 7 pad bits
        start_test(1'b1);
        for (int i = 0; i < 9; i++) begin
            push(1'b1, 8'(8'hF0 ^ i * 29)); exp_word(1'b1, 8'(8'hF0 ^ i * 29));
        end
        pulse_flush(); exp_pad(7);
        wait_idle();
        compare("R10 group rollover", 1);

        // R6 one word plus flush: 7 pad bits
        start_test(1'b1);
        push(1'b0, 8'h29); exp_word(1'b0, 8'h29);
        pulse_flush(); exp_pad(7);
        wait_idle();
        compare("R6 flush one word", 1);

        // R6 seven words plus flush: 1 pad bit
        start_test(1'b1);
        for (int i = 0; i < 7; i++) begin
            push(1'b1, 8'(i * 71)); exp_word(1'b1, 8'(i * 71));
        end
        pulse_flush(); exp_pad(1);
        wait_idle();
        compare("R6 flush seven words", 1);

        // R7 flush while idle is ignored
        start_test(1'b1);
        pulse_flush();
        repeat (5 * DIV) @(negedge clk);
        chk(cs_n == 1'b1, "R7 idle flush cs_n", cs_n, 1);
        chk(got.size() == 0, "R7 idle flush bits", got.size(), 0);

        // R9 flush during a native word holds off the next item
        start_test(1'b0);
        push(1'b0, 8'h36); exp_word(1'b0, 8'h36);
        fork
            begin
                pulse_flush();
                #1;
                chk(in_ready == 1'b0, "R9 flush pending blocks", in_ready, 0);
            end
            push(1'b1, 8'h48);
        join
        exp_word(1'b1, 8'h48);
        wait_idle();
        compare("R9 flush splits burst", 2);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule